// File: doc/BRIEF.md
# DMA Channel Interrupt Status Combiner

This block gathers completion, termination and bus-error events from a bank of DMA channels into two 32-bit status registers. Software reaches each register through a set alias and a clear alias. The block drives one interrupt line. It also presents pending events one at a time on a servicing port, so that a handler can work through them in a fixed priority order and acknowledge each one.

The first register holds a completion flag for each channel in its low half and an interrupt enable for each channel in its high half. The second register holds a termination flag for each channel in its low half and a bus-error qualifier in its high half.

Events are classified before they are serviced. A bus error is a channel with both of its bits set in the second register. A termination that arrives together with a completion is treated as an ordinary completion. A termination with no completion is an error. The errors occupy the upper half of a 32-bit service vector and the completions occupy the lower half. The vector is drained from its highest set bit downward, so every error is handled before any completion.

Top module: `dmaint_combiner`

## Requirements
- R1: After reset both status registers read zero, `irq_o` is low and `svc_valid_o` is low.
- R2: A write with `wr_clr_i`=0 goes to the set alias. It sets every bit of the selected register whose data bit is 1 and leaves the other bits unchanged. When a set and a clear of the same bit happen in one cycle, the set wins.
- R3: A write with `wr_clr_i`=1 goes to the clear alias. It clears every bit of the selected register whose data bit is 1 and leaves the other bits unchanged.
- R4: Hardware events are recorded as follows:
  - a pulse on `cmpl_i[k]` sets bit k of the completion register;
  - a pulse on `term_i[k]` sets bit k of the termination register;
  - a pulse on `berr_i[k]` sets bits k and k+16 of the termination register.
- R5: A flag set by hardware in the same cycle that software or an acknowledge clears it stays set.
- R6: Channel k is a bus error when bits k and k+16 of the termination register are both set. It is then reported at service index 16+k.
- R7: Channel k is a termination error when termination bit k is set, bit k+16 is clear and completion bit k is clear. It is then reported at index 16+k. If completion bit k is set at the same time, no error is reported, only completion index k.
- R8: `svc_idx_o` shows the highest set index of the vector {errors[31:16], completions[15:0]}, and `svc_valid_o` shows that at least one index is pending.
- R9: An acknowledge removes the reported event, and the next index appears on the following cycle.
  - Acknowledging completion index k clears completion bit k and termination bit k.
  - Acknowledging error index 16+k clears termination bits k and k+16.
  - `svc_ack_i` while `svc_valid_o` is low changes nothing.
- R10: `irq_o` is the OR of every completion flag whose enable (completion register bit k+16) is set, together with every error. A completion whose enable is clear is still serviced but does not raise `irq_o`.
- R11: Clearing both registers through their clear aliases drops `irq_o` after the clock edge of the last of those writes.
- R12: `wr_reg_i` and `rd_reg_i` select the register: 0 selects the completion register and 1 selects the termination register. A write changes only the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmpl_i | input | 16 | Per-channel completion pulses |
| term_i | input | 16 | Per-channel termination pulses |
| berr_i | input | 16 | Per-channel bus-error pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_reg_i | input | 1 | Write target: 0 completion, 1 termination |
| wr_clr_i | input | 1 | Alias: 0 set, 1 clear |
| wr_data_i | input | 32 | Write mask |
| rd_reg_i | input | 1 | Read select: 0 completion, 1 termination |
| rd_data_o | output | 32 | Selected register contents |
| irq_o | output | 1 | Combined interrupt |
| svc_valid_o | output | 1 | An event is pending |
| svc_idx_o | output | 5 | Highest pending service index |
| svc_ack_i | input | 1 | Acknowledge the shown index |

## Verification
The bench builds the block with its default of sixteen channels. At that size the service vector is the full 32 bits, and a write of 0xFFFF0000 to the set alias enables every channel. Both halves of each register are therefore exercised, including the error indices 16 to 31 that outrank every completion. The scoreboard drains mixed bursts of events in which a bus error, a bare termination and a termination that coincides with a completion all arrive together. The order in which those events come out shows both the classification and the priority.

// File: rtl/dmaint_pkg.sv
package dmaint_pkg;
  typedef enum logic { REG_CMPL = 1'b0, REG_TERM = 1'b1 } reg_sel_e;
  typedef enum logic { ALIAS_SET = 1'b0, ALIAS_CLR = 1'b1 } alias_e;
endpackage

// File: rtl/dmaint_flag_bank.sv
module dmaint_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  // sets (hardware or software) override clears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i | hw_set_i;
  end
endmodule

// File: rtl/dmaint_qualify.sv
module dmaint_qualify #(
  parameter int N_CH = 16,
  localparam int W = 2 * N_CH
) (
  input  logic [W-1:0] stat_a_i,
  input  logic [W-1:0] stat_b_i,
  output logic [W-1:0] vec_o,
  output logic         irq_o
);
  logic [N_CH-1:0] err;
  logic [N_CH-1:0] cmpl_en;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    // bus error: both halves; bare termination: low half without completion
    assign err[k] = stat_b_i[k] & (stat_b_i[N_CH+k] | ~stat_a_i[k]);
    assign cmpl_en[k] = stat_a_i[k] & stat_a_i[N_CH+k];
  end

  assign vec_o = {err, stat_a_i[N_CH-1:0]};
  assign irq_o = (|cmpl_en) | (|err);
endmodule

// File: rtl/dmaint_prio_enc.sv
module dmaint_prio_enc #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |vec_i;
endmodule

// File: rtl/dmaint_combiner.sv
module dmaint_combiner #(
  parameter int N_CH = 16,
  localparam int W  = 2 * N_CH,
  localparam int CW = $clog2(N_CH),
  localparam int IW = CW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] cmpl_i,
  input  logic [N_CH-1:0] term_i,
  input  logic [N_CH-1:0] berr_i,
  input  logic            wr_en_i,
  input  logic            wr_reg_i,
  input  logic            wr_clr_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            rd_reg_i,
  output logic [W-1:0]    rd_data_o,
  output logic            irq_o,
  output logic            svc_valid_o,
  output logic [IW-1:0]   svc_idx_o,
  input  logic            svc_ack_i
);
  import dmaint_pkg::*;

  logic [W-1:0] stat_a_q, stat_b_q;
  logic [W-1:0] set_a, clr_a, set_b, clr_b;
  logic [W-1:0] ack_a, ack_b;
  logic [W-1:0] svc_vec;
  logic [W-1:0] ch_mask;
  logic         sel_a, sel_b, ack_fire, ack_err;

  assign sel_a = wr_en_i && (reg_sel_e'(wr_reg_i) == REG_CMPL);
  assign sel_b = wr_en_i && (reg_sel_e'(wr_reg_i) == REG_TERM);

  assign set_a = (sel_a && alias_e'(wr_clr_i) == ALIAS_SET) ? wr_data_i : '0;
  assign clr_a = (sel_a && alias_e'(wr_clr_i) == ALIAS_CLR) ? wr_data_i : '0;
  assign set_b = (sel_b && alias_e'(wr_clr_i) == ALIAS_SET) ? wr_data_i : '0;
  assign clr_b = (sel_b && alias_e'(wr_clr_i) == ALIAS_CLR) ? wr_data_i : '0;

  // acknowledge retires the shown event at its source bits
  assign ack_fire = svc_ack_i && svc_valid_o;
  assign ack_err  = svc_idx_o[CW];
  assign ch_mask  = {{(W-1){1'b0}}, 1'b1} << svc_idx_o[CW-1:0];
  assign ack_a    = (ack_fire && !ack_err) ? ch_mask : '0;
  assign ack_b    = !ack_fire ? '0
                  : ack_err ? (ch_mask | (ch_mask << N_CH)) : ch_mask;

  dmaint_flag_bank #(.W(W)) bank_a_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_a),
    .clr_i    (clr_a | ack_a),
    .hw_set_i ({{N_CH{1'b0}}, cmpl_i}),
    .q_o      (stat_a_q)
  );

  dmaint_flag_bank #(.W(W)) bank_b_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_b),
    .clr_i    (clr_b | ack_b),
    .hw_set_i ({berr_i, term_i | berr_i}),
    .q_o      (stat_b_q)
  );

  dmaint_qualify #(.N_CH(N_CH)) qual_i (
    .stat_a_i (stat_a_q),
    .stat_b_i (stat_b_q),
    .vec_o    (svc_vec),
    .irq_o    (irq_o)
  );

  dmaint_prio_enc #(.W(W)) enc_i (
    .vec_i   (svc_vec),
    .valid_o (svc_valid_o),
    .idx_o   (svc_idx_o)
  );

  assign rd_data_o = (reg_sel_e'(rd_reg_i) == REG_TERM) ? stat_b_q : stat_a_q;
endmodule

// File: rtl/dmaint_combiner_chk.sv
module dmaint_combiner_chk #(
  parameter int N_CH = 16,
  localparam int W  = 2 * N_CH,
  localparam int CW = $clog2(N_CH),
  localparam int IW = CW + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] cmpl_i,
  input logic [N_CH-1:0] term_i,
  input logic [N_CH-1:0] berr_i,
  input logic            wr_en_i,
  input logic            wr_reg_i,
  input logic            wr_clr_i,
  input logic [W-1:0]    wr_data_i,
  input logic            irq_o,
  input logic            svc_valid_o,
  input logic [IW-1:0]   svc_idx_o,
  input logic            svc_ack_i,
  input logic [W-1:0]    stat_a_q
);
  a_r5_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmpl_i) |=> ((stat_a_q[N_CH-1:0] & $past(cmpl_i)) == $past(cmpl_i)));

  a_r2_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_reg_i && !wr_clr_i)
      |=> ((stat_a_q & $past(wr_data_i)) == $past(wr_data_i)));

  a_r10_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> svc_valid_o);

  a_r6_err_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_valid_o && svc_idx_o[CW]) |-> irq_o);

  a_r9_ack_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_valid_o && svc_ack_i && !wr_en_i && !(|{cmpl_i, term_i, berr_i}))
      |=> (!svc_valid_o || svc_idx_o != $past(svc_idx_o)));
endmodule

bind dmaint_combiner dmaint_combiner_chk #(.N_CH(N_CH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmpl_i      (cmpl_i),
  .term_i      (term_i),
  .berr_i      (berr_i),
  .wr_en_i     (wr_en_i),
  .wr_reg_i    (wr_reg_i),
  .wr_clr_i    (wr_clr_i),
  .wr_data_i   (wr_data_i),
  .irq_o       (irq_o),
  .svc_valid_o (svc_valid_o),
  .svc_idx_o   (svc_idx_o),
  .svc_ack_i   (svc_ack_i),
  .stat_a_q    (stat_a_q)
);

// File: tb/dmaint_combiner_tb_top.sv
module dmaint_combiner_tb_top;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] cmpl_i = '0, term_i = '0, berr_i = '0;
  logic        wr_en_i = 1'b0, wr_reg_i = 1'b0, wr_clr_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_reg_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o, svc_valid_o;
  logic [4:0]  svc_idx_o;
  logic        mon_ack = 1'b0, man_ack = 1'b0, drain_en = 1'b0;
  logic        svc_ack_i;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int cyc = 0;

  assign svc_ack_i = mon_ack | man_ack;

  always #5 clk_i = ~clk_i;

  dmaint_combiner #(.N_CH(N)) dut_i (
    .clk_i, .rst_ni, .cmpl_i, .term_i, .berr_i,
    .wr_en_i, .wr_reg_i, .wr_clr_i, .wr_data_i,
    .rd_reg_i, .rd_data_o, .irq_o, .svc_valid_o, .svc_idx_o, .svc_ack_i
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic r, logic c, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_reg_i = r; wr_clr_i = c; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse(logic [N-1:0] c, logic [N-1:0] t, logic [N-1:0] b);
    @(negedge clk_i);
    cmpl_i = c; term_i = t; berr_i = b;
    @(negedge clk_i);
    cmpl_i = '0; term_i = '0; berr_i = '0;
  endtask

  task automatic rd(string req, logic r, logic [31:0] exp);
    rd_reg_i = r;
    #1;
    check(req, rd_data_o, exp);
  endtask

  // monitor: pops expected indices and acknowledges each one shown
  always @(negedge clk_i) begin
    if (drain_en && svc_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected index", 32'(svc_idx_o), 32'hFFFF_FFFF);
      end else begin
        check("R8 service order", 32'(svc_idx_o), 32'(exp_q.pop_front()));
      end
      mon_ack = 1'b1;
    end else begin
      mon_ack = 1'b0;
    end
  end

  task automatic drain();
    drain_en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      #1;
      if (exp_q.size() == 0 && !svc_valid_o) break;
    end
    drain_en = 1'b0;
    check("R9 queue drained", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1
    rd("R1 reset reg A", 1'b0, 32'h0);
    rd("R1 reset reg B", 1'b1, 32'h0);
    check("R1 irq low", 32'(irq_o), 32'd0);
    check("R1 valid low", 32'(svc_valid_o), 32'd0);

    // R2 R12: enable all channels
    wr(1'b0, 1'b0, 32'hFFFF_0000);
    rd("R2 set alias", 1'b0, 32'hFFFF_0000);
    rd("R12 other register untouched", 1'b1, 32'h0);
    check("R10 enables alone no irq", 32'(irq_o), 32'd0);

    // R4 R8 R10: two completions
    pulse(16'h0208, '0, '0);
    rd("R4 completion flags", 1'b0, 32'hFFFF_0208);
    check("R10 enabled completion irq", 32'(irq_o), 32'd1);
    exp_q.push_back(9); exp_q.push_back(3);
    drain();
    rd("R9 completions retired", 1'b0, 32'hFFFF_0000);
    check("R9 irq after drain", 32'(irq_o), 32'd0);

    // R3: disable channels 4..7
    wr(1'b0, 1'b1, 32'h00F0_0000);
    rd("R3 clear alias", 1'b0, 32'hFF0F_0000);

    // R10: disabled channel still serviced, no irq
    pulse(16'h0020, '0, '0);
    check("R10 disabled completion no irq", 32'(irq_o), 32'd0);
    check("R10 disabled completion pending", 32'(svc_valid_o), 32'd1);
    check("R8 index of disabled completion", 32'(svc_idx_o), 32'd5);
    exp_q.push_back(5);
    drain();

    // R6 R7 R8: bus error ch1, bare termination ch2, coincident ch7
    pulse(16'h0080, 16'h0084, 16'h0002);
    rd("R4 termination register", 1'b1, 32'h0002_0086);
    rd("R4 completion register", 1'b0, 32'hFF0F_0080);
    check("R7 error raises irq", 32'(irq_o), 32'd1);
    check("R7 bare termination first", 32'(svc_idx_o), 32'd18);
    exp_q.push_back(18); exp_q.push_back(17); exp_q.push_back(7);
    drain();
    rd("R9 termination register cleared", 1'b1, 32'h0);
    rd("R9 completion register cleared", 1'b0, 32'hFF0F_0000);

    // R5: software clear collides with hardware set
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_reg_i = 1'b0; wr_clr_i = 1'b1; wr_data_i = 32'h0000_FFFF;
    cmpl_i = 16'h1000;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0; cmpl_i = '0;
    rd("R5 hw set beats sw clear", 1'b0, 32'hFF0F_1000);
    // R5: acknowledge collides with hardware set
    @(negedge clk_i);
    man_ack = 1'b1; cmpl_i = 16'h1000;
    @(negedge clk_i);
    man_ack = 1'b0; cmpl_i = '0;
    #1;
    check("R5 hw set beats ack", 32'(svc_idx_o), 32'd12);
    rd("R5 flag kept after ack", 1'b0, 32'hFF0F_1000);
    exp_q.push_back(12);
    drain();

    // R11
    wr(1'b0, 1'b0, 32'hFFFF_0003);
    wr(1'b1, 1'b0, 32'h0000_0004);
    check("R11 irq before clears", 32'(irq_o), 32'd1);
    wr(1'b0, 1'b1, 32'hFFFF_FFFF);
    check("R11 irq held by error", 32'(irq_o), 32'd1);
    wr(1'b1, 1'b1, 32'hFFFF_FFFF);
    check("R11 irq after both cleared", 32'(irq_o), 32'd0);
    check("R11 nothing pending", 32'(svc_valid_o), 32'd0);

    // R9: ack with nothing pending is ignored
    wr(1'b0, 1'b0, 32'hFFFF_0000);
    @(negedge clk_i);
    man_ack = 1'b1;
    @(negedge clk_i);
    man_ack = 1'b0;
    rd("R9 stray ack reg A", 1'b0, 32'hFFFF_0000);
    rd("R9 stray ack reg B", 1'b1, 32'h0);

    // R12: qualifier alone in reg B is not an error
    wr(1'b1, 1'b0, 32'h0001_0000);
    rd("R12 write lands in reg B", 1'b1, 32'h0001_0000);
    rd("R12 reg A unchanged", 1'b0, 32'hFFFF_0000);
    check("R6 qualifier alone no event", 32'(svc_valid_o), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule